// File: doc/BRIEF.md
# Walker Memory Request Scheduler

This block sits between a page-table walk state machine and a single memory port. The walker hands it read requests for the next table level and write-backs that set the accessed bit of entries it has already used. The scheduler keeps at most one read waiting and a small last-in first-out stack of write-backs. It offers them to the port one per cycle, always the read first, and copes with a port that refuses requests or returns negative acknowledgements.

A refused request stops all ordinary issuing until the port pulses its retry line. A nacked request is offered again in the very cycle its nack arrives, ahead of everything else and even while issuing is frozen. If that resend is refused, the request goes back where it came from: the read slot or the top of the stack. Counters track the requests in flight, and a one-cycle done pulse is raised only once every request has been answered and nothing is waiting.

The walker is expected to push its follow-on read and write-back in the same cycle as the read response that caused them. It may push at most one read while none is waiting, and must not push a write while the full flag is high.

Top module: `walk_req_sched`

## Requirements
- R1: When a read is waiting, issuing is not frozen and no nack arrives, the port request is that read (mem_req_write = 0) and no write-back is offered.
- R2: A request offered with mem_req_accept low freezes ordinary issuing from the next cycle. Only nack resends appear until a mem_retry pulse is seen; issuing resumes in the cycle after the pulse.
- R3: Write-backs leave the stack newest first, one per cycle, for as long as the port accepts them and no read is waiting.
- R4: walk_done is high for exactly one cycle when a walk is active, no request is in flight, no read is waiting and the stack is empty. A walk becomes active on any push and goes idle after done.
- R5: In a cycle with mem_rsp_valid and mem_rsp_nack high, the port request is a copy of the nacked request (same write flag, address and, for writes, data), whatever else is waiting and even while issuing is frozen. If refused, a read returns to the read slot, a write goes on top of the stack, and issuing freezes.
- R6: A read response that is not nacked is passed to the walker in the same cycle on walk_rdata_valid and walk_rdata. Write responses and nacks never raise walk_rdata_valid.
- R7: wr_full is high when waiting write-backs plus write-backs in flight reach WB_DEPTH, so the stack never holds more than WB_DEPTH entries.
- R8: After reset no request is offered, wr_full and walk_done are low, and no walk is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_push_valid | input | 1 | Walker pushes a read |
| rd_push_addr | input | ADDR_W | Address of the pushed read |
| wr_push_valid | input | 1 | Walker pushes a write-back |
| wr_push_addr | input | ADDR_W | Address of the pushed write-back |
| wr_push_data | input | DATA_W | Data of the pushed write-back |
| wr_full | output | 1 | No room for another write-back |
| walk_rdata_valid | output | 1 | Read data returned to the walker |
| walk_rdata | output | DATA_W | Read data for the walker |
| walk_done | output | 1 | One-cycle pulse: all traffic drained |
| mem_req_valid | output | 1 | Request offered to the port |
| mem_req_write | output | 1 | Offered request is a write |
| mem_req_addr | output | ADDR_W | Address of the offered request |
| mem_req_wdata | output | DATA_W | Write data (zero for reads) |
| mem_req_accept | input | 1 | Port takes the offered request this cycle |
| mem_rsp_valid | input | 1 | Response or nack from the port |
| mem_rsp_nack | input | 1 | The response is a negative acknowledgement |
| mem_rsp_write | input | 1 | The response belongs to a write |
| mem_rsp_addr | input | ADDR_W | Address of the answered request |
| mem_rsp_data | input | DATA_W | Read data, or the original write data on a nack |
| mem_retry | input | 1 | One-cycle pulse: the port can take requests again |

## Verification
The bench runs multi-level walks against a memory model in four regimes: a port that accepts everything, one that refuses often and retries slowly, one that nacks often, and one that does both at once. The clean regime pins down the plain read-then-writes order and done timing; the refusing regime fills the stack and shows the freeze and newest-first draining; the nacking regime separates resend priority and the return of refused resends to the slot or stack; the mixed regime makes all of these collide with the full flag. Every cycle the offered request, full flag, read data and done are compared with a behavioural queue model.

// File: rtl/walk_req_sched_pkg.sv
package walk_req_sched_pkg;

    parameter int ADDR_W = 32;
    parameter int DATA_W = 64;

    // Which source drives the port this cycle
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_NACK  = 2'd1,
        SRC_READ  = 2'd2,
        SRC_STACK = 2'd3
    } req_src_e;

    typedef struct packed {
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } mem_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wb_entry_t;

    function automatic mem_req_t make_read(input logic [ADDR_W-1:0] a);
        mem_req_t r;
        r.is_wr = 1'b0;
        r.addr  = a;
        r.data  = '0;
        return r;
    endfunction

    function automatic mem_req_t make_write(input wb_entry_t e);
        mem_req_t r;
        r.is_wr = 1'b1;
        r.addr  = e.addr;
        r.data  = e.data;
        return r;
    endfunction

endpackage

// File: rtl/wrs_flight_ctr.sv
module wrs_flight_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + W'(inc) - W'(dec);
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/wrs_wb_stack.sv
module wrs_wb_stack
    import walk_req_sched_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic             push_ret,
    input  wb_entry_t        ret_entry,
    input  logic             push_new,
    input  wb_entry_t        new_entry,
    output wb_entry_t        top,
    output logic             empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int SW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    wb_entry_t     slots [DEPTH];
    logic [SW-1:0] cnt_q;
    logic [SW-1:0] base;
    logic [SW-1:0] idx_ret;
    logic [SW-1:0] idx_new;
    logic [SW-1:0] top_idx;

    // pop first, then the returned entry, then the walker's entry on top
    assign base    = cnt_q - SW'(pop);
    assign idx_ret = base;
    assign idx_new = base + SW'(push_ret);
    assign top_idx = (cnt_q == '0) ? '0 : cnt_q - SW'(1);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ret && idx_ret == SW'(i))
                slots[i] <= ret_entry;
            else if (push_new && idx_new == SW'(i))
                slots[i] <= new_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= base + SW'(push_ret) + SW'(push_new);
    end

    assign top   = slots[top_idx[IW-1:0]];
    assign empty = (cnt_q == '0);
    assign count = cnt_q;
endmodule

// File: rtl/wrs_port_arb.sv
module wrs_port_arb
    import walk_req_sched_pkg::*;
(
    input  logic     nack_in,
    input  mem_req_t nack_req,
    input  logic     frozen,
    input  logic     rd_pending,
    input  mem_req_t rd_req,
    input  logic     stk_nonempty,
    input  mem_req_t stk_req,
    output logic     out_valid,
    output mem_req_t out_req,
    output req_src_e out_src
);
    // nack resend > waiting read > stack top; the last two only when not frozen
    always_comb begin
        out_valid = 1'b0;
        out_req   = '0;
        out_src   = SRC_NONE;
        if (nack_in) begin
            out_valid = 1'b1;
            out_req   = nack_req;
            out_src   = SRC_NACK;
        end else if (!frozen && rd_pending) begin
            out_valid = 1'b1;
            out_req   = rd_req;
            out_src   = SRC_READ;
        end else if (!frozen && stk_nonempty) begin
            out_valid = 1'b1;
            out_req   = stk_req;
            out_src   = SRC_STACK;
        end
    end
endmodule

// File: rtl/walk_req_sched.sv
module walk_req_sched
    import walk_req_sched_pkg::*;
#(
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_push_valid,
    input  logic [ADDR_W-1:0] rd_push_addr,
    input  logic              wr_push_valid,
    input  logic [ADDR_W-1:0] wr_push_addr,
    input  logic [DATA_W-1:0] wr_push_data,
    output logic              wr_full,
    output logic              walk_rdata_valid,
    output logic [DATA_W-1:0] walk_rdata,
    output logic              walk_done,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_req_accept,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_nack,
    input  logic              mem_rsp_write,
    input  logic [ADDR_W-1:0] mem_rsp_addr,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_retry
);
    localparam int SW = $clog2(WB_DEPTH + 1);
    localparam int CW = $clog2(WB_DEPTH + 2);

    logic              rd_pend_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              retry_q;
    logic              busy_q;

    wb_entry_t         stk_top;
    logic              stk_empty;
    logic [SW-1:0]     stk_cnt;
    logic [CW-1:0]     all_infl;
    logic [SW-1:0]     wr_infl;

    logic              nack_in;
    mem_req_t          nack_req;
    logic              arb_valid;
    mem_req_t          arb_req;
    req_src_e          arb_src;
    logic              taken;
    logic              refused;
    logic              ret_write;
    logic              ret_read;
    wb_entry_t         ret_entry;
    wb_entry_t         new_entry;

    assign nack_in        = mem_rsp_valid && mem_rsp_nack;
    assign nack_req.is_wr = mem_rsp_write;
    assign nack_req.addr  = mem_rsp_addr;
    assign nack_req.data  = mem_rsp_write ? mem_rsp_data : '0;

    wrs_port_arb u_arb (
        .nack_in      (nack_in),
        .nack_req     (nack_req),
        .frozen       (retry_q),
        .rd_pending   (rd_pend_q),
        .rd_req       (make_read(rd_addr_q)),
        .stk_nonempty (!stk_empty),
        .stk_req      (make_write(stk_top)),
        .out_valid    (arb_valid),
        .out_req      (arb_req),
        .out_src      (arb_src)
    );

    assign taken     = arb_valid && mem_req_accept;
    assign refused   = arb_valid && !mem_req_accept;
    assign ret_write = (arb_src == SRC_NACK) && refused && mem_rsp_write;
    assign ret_read  = (arb_src == SRC_NACK) && refused && !mem_rsp_write;

    assign ret_entry.addr = mem_rsp_addr;
    assign ret_entry.data = mem_rsp_data;
    assign new_entry.addr = wr_push_addr;
    assign new_entry.data = wr_push_data;

    wrs_wb_stack #(.DEPTH(WB_DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .pop       (taken && arb_src == SRC_STACK),
        .push_ret  (ret_write),
        .ret_entry (ret_entry),
        .push_new  (wr_push_valid),
        .new_entry (new_entry),
        .top       (stk_top),
        .empty     (stk_empty),
        .count     (stk_cnt)
    );

    wrs_flight_ctr #(.W(CW)) u_all_ctr (
        .clk (clk),
        .rst (rst),
        .inc (taken),
        .dec (mem_rsp_valid),
        .cnt (all_infl)
    );

    wrs_flight_ctr #(.W(SW)) u_wr_ctr (
        .clk (clk),
        .rst (rst),
        .inc (taken && arb_req.is_wr),
        .dec (mem_rsp_valid && mem_rsp_write),
        .cnt (wr_infl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend_q <= 1'b0;
            rd_addr_q <= '0;
        end else if (rd_push_valid) begin
            rd_pend_q <= 1'b1;
            rd_addr_q <= rd_push_addr;
        end else if (ret_read) begin
            rd_pend_q <= 1'b1;
            rd_addr_q <= mem_rsp_addr;
        end else if (taken && arb_src == SRC_READ) begin
            rd_pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            retry_q <= 1'b0;
        else if (refused)   retry_q <= 1'b1;
        else if (mem_retry) retry_q <= 1'b0;
    end

    assign walk_done = busy_q && (all_infl == '0) && !rd_pend_q && stk_empty;

    always_ff @(posedge clk) begin
        if (rst)                                busy_q <= 1'b0;
        else if (rd_push_valid || wr_push_valid) busy_q <= 1'b1;
        else if (walk_done)                     busy_q <= 1'b0;
    end

    assign wr_full = ({1'b0, stk_cnt} + {1'b0, wr_infl}) >= (SW + 1)'(WB_DEPTH);

    assign walk_rdata_valid = mem_rsp_valid && !mem_rsp_nack && !mem_rsp_write;
    assign walk_rdata       = mem_rsp_data;

    assign mem_req_valid = arb_valid;
    assign mem_req_write = arb_req.is_wr;
    assign mem_req_addr  = arb_req.addr;
    assign mem_req_wdata = arb_req.data;
endmodule

// File: rtl/walk_req_sched_chk.sv
module walk_req_sched_chk #(
    parameter int WB_DEPTH = 4,
    parameter int SW = 3,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req_valid,
    input logic          mem_req_write,
    input logic [AW-1:0] mem_req_addr,
    input logic          mem_req_accept,
    input logic          mem_rsp_valid,
    input logic          mem_rsp_nack,
    input logic          mem_rsp_write,
    input logic [AW-1:0] mem_rsp_addr,
    input logic          walk_done,
    input logic          rd_pend_q,
    input logic          retry_q,
    input logic [SW-1:0] stk_cnt
);
    // R1
    read_first_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_pend_q && !retry_q && !(mem_rsp_valid && mem_rsp_nack))
        |-> (mem_req_valid && !mem_req_write));

    // R2
    freeze_after_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_accept)
        |=> (!mem_req_valid || (mem_rsp_valid && mem_rsp_nack)));

    // R5
    nack_resend_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rsp_valid && mem_rsp_nack)
        |-> (mem_req_valid && mem_req_write == mem_rsp_write
             && mem_req_addr == mem_rsp_addr));

    // R5
    nack_read_return_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rsp_valid && mem_rsp_nack && !mem_rsp_write && !mem_req_accept)
        |=> rd_pend_q);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> !walk_done);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        stk_cnt <= SW'(WB_DEPTH));
endmodule

bind walk_req_sched walk_req_sched_chk #(
    .WB_DEPTH (WB_DEPTH),
    .SW       ($clog2(WB_DEPTH + 1)),
    .AW       (walk_req_sched_pkg::ADDR_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .mem_req_valid  (mem_req_valid),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr),
    .mem_req_accept (mem_req_accept),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_nack   (mem_rsp_nack),
    .mem_rsp_write  (mem_rsp_write),
    .mem_rsp_addr   (mem_rsp_addr),
    .walk_done      (walk_done),
    .rd_pend_q      (rd_pend_q),
    .retry_q        (retry_q),
    .stk_cnt        (stk_cnt)
);

// File: tb/walk_req_sched_test.sv
`timescale 1ns/1ps
module walk_req_sched_test;
    localparam int DEPTH = 4;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_push_valid = 0;
    logic [31:0] rd_push_addr = '0;
    logic        wr_push_valid = 0;
    logic [31:0] wr_push_addr = '0;
    logic [63:0] wr_push_data = '0;
    logic        wr_full, walk_rdata_valid, walk_done;
    logic [63:0] walk_rdata;
    logic        mem_req_valid, mem_req_write;
    logic [31:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_req_accept = 0;
    logic        mem_rsp_valid = 0, mem_rsp_nack = 0, mem_rsp_write = 0;
    logic [31:0] mem_rsp_addr = '0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_retry = 0;

    walk_req_sched #(.WB_DEPTH(DEPTH)) uut (.*);

    always #4 clk = ~clk;

    typedef struct { bit wr; logic [31:0] addr; logic [63:0] data; int due; } mpkt_t;
    typedef struct { logic [31:0] addr; logic [63:0] data; } went_t;

    int total = 0, bad = 0, cyc = 0;
    bit wd_hit = 0;

    // reference model state
    bit          m_rd_pend = 0;
    logic [31:0] m_rd_addr = '0;
    went_t       m_stk[$];
    bit          m_retry = 0;
    int          m_infl = 0, m_wrinfl = 0;
    bit          m_busy = 0;

    mpkt_t memq[$];
    went_t w_wq[$];
    int max_stk = 0, nack_ret = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s cycle %0d actual=%h expected=%h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic run_phase(input int p_acc, input int p_nack, input int p_retry,
                             input int p_lat, input int nwalks);
        int started = 0, dones = 0, levels = 0, gap = 0;
        while (!wd_hit && !(started == nwalks && !m_busy && w_wq.size() == 0
                             && memq.size() == 0)) begin
            bit rv, rn, rw, acc, rty, rdv, wrv, ev, ewr, e_full, e_done, e_rdv;
            bit taken, refused;
            logic [31:0] ra, rda, ea;
            logic [63:0] rd_d, ed;
            went_t wn;
            int src;
            string tg;
            @(negedge clk);
            cyc++;
            if (cyc > LIMIT) begin
                wd_hit = 1; total++; bad++;
                $display("FAIL R4 watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
                break;
            end
            rv = 0; rn = 0; rw = 0; ra = '0; rd_d = '0;
            if (memq.size() > 0 && memq[0].due <= cyc) begin
                mpkt_t p = memq.pop_front();
                rv = 1; rw = p.wr; ra = p.addr;
                rn = ($urandom_range(99) < p_nack);
                rd_d = p.wr ? p.data : {~p.addr, p.addr};
            end
            e_full = (m_stk.size() + m_wrinfl) >= DEPTH;
            e_done = m_busy && m_infl == 0 && !m_rd_pend && m_stk.size() == 0;
            e_rdv  = rv && !rn && !rw;
            // walker
            rdv = 0; wrv = 0; rda = '0;
            if (e_rdv) begin
                if (levels > 0) begin rdv = 1; rda = ra + 32'h1000; levels--; end
                w_wq.push_back('{ra, rd_d | 64'h20});
            end else if (!m_busy && !rv && w_wq.size() == 0 && started < nwalks && gap == 0) begin
                rdv = 1; rda = 32'h0010_0000 + 32'(started * 64);
                levels = $urandom_range(1, 4) - 1; started++;
            end
            if (gap > 0) gap--;
            wn = '{'0, '0};
            if (w_wq.size() > 0 && !e_full) begin wrv = 1; wn = w_wq.pop_front(); end
            acc = ($urandom_range(99) < p_acc);
            rty = m_retry ? ($urandom_range(99) < p_retry) : ($urandom_range(99) < 3);
            rd_push_valid = rdv; rd_push_addr = rda;
            wr_push_valid = wrv; wr_push_addr = wn.addr; wr_push_data = wn.data;
            mem_req_accept = acc; mem_retry = rty;
            mem_rsp_valid = rv; mem_rsp_nack = rn; mem_rsp_write = rw;
            mem_rsp_addr = ra; mem_rsp_data = rd_d;
            #1;
            // expected request
            ev = 0; ewr = 0; ea = '0; ed = '0; src = 0;
            if (rv && rn) begin ev = 1; ewr = rw; ea = ra; ed = rd_d; src = 1; end
            else if (!m_retry && m_rd_pend) begin ev = 1; ea = m_rd_addr; src = 2; end
            else if (!m_retry && m_stk.size() > 0) begin
                ev = 1; ewr = 1; ea = m_stk[$].addr; ed = m_stk[$].data; src = 3;
            end
            tg = (src == 1 || (rv && rn)) ? "R5" : m_retry ? "R2" : m_rd_pend ? "R1" : "R3";
            chk(mem_req_valid == ev, tg, "req_valid", 64'(mem_req_valid), 64'(ev));
            if (ev && mem_req_valid) begin
                chk(mem_req_write == ewr, tg, "req_write", 64'(mem_req_write), 64'(ewr));
                chk(mem_req_addr == ea, tg, "req_addr", 64'(mem_req_addr), 64'(ea));
                if (ewr) chk(mem_req_wdata == ed, tg, "req_wdata", mem_req_wdata, ed);
            end
            chk(wr_full == e_full, "R7", "wr_full", 64'(wr_full), 64'(e_full));
            chk(walk_done == e_done, "R4", "walk_done", 64'(walk_done), 64'(e_done));
            chk(walk_rdata_valid == e_rdv, "R6", "rdata_valid",
                64'(walk_rdata_valid), 64'(e_rdv));
            if (e_rdv) chk(walk_rdata == rd_d, "R6", "rdata", walk_rdata, rd_d);
            if (walk_done) dones++;
            // model update
            taken = ev && acc; refused = ev && !acc;
            m_infl   += int'(taken) - int'(rv);
            m_wrinfl += int'(taken && ewr) - int'(rv && rw);
            if (src == 2 && taken) m_rd_pend = 0;
            if (src == 3 && taken) void'(m_stk.pop_back());
            if (src == 1 && refused) begin
                nack_ret++;
                if (rw) m_stk.push_back('{ra, rd_d});
                else begin m_rd_pend = 1; m_rd_addr = ra; end
            end
            if (rdv) begin m_rd_pend = 1; m_rd_addr = rda; end
            if (wrv) m_stk.push_back(wn);
            if (refused) m_retry = 1; else if (rty) m_retry = 0;
            if (rdv || wrv) m_busy = 1; else if (e_done) begin m_busy = 0; gap = $urandom_range(0, 3); end
            if (m_stk.size() > max_stk) max_stk = m_stk.size();
            if (taken) memq.push_back('{ewr, ea, ed, cyc + $urandom_range(1, p_lat)});
        end
        // R4: one done pulse per walk
        chk(dones == nwalks, "R4", "done pulses in phase", 64'(dones), 64'(nwalks));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(mem_req_valid == 0, "R8", "req_valid in reset", 64'(mem_req_valid), 0);
        chk(wr_full == 0, "R8", "wr_full in reset", 64'(wr_full), 0);
        chk(walk_done == 0, "R8", "walk_done in reset", 64'(walk_done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_req_valid == 0 && walk_done == 0, "R8", "idle after reset",
            64'({mem_req_valid, walk_done}), 0);
        run_phase(100, 0, 100, 2, 20);
        run_phase(35, 0, 15, 3, 25);
        run_phase(100, 40, 100, 4, 25);
        run_phase(45, 35, 25, 5, 30);
        // R3 the stack was driven to hold several entries
        chk(max_stk >= 2, "R3", "stack depth reached", 64'(max_stk), 2);
        // R5 refused nack resends were returned
        chk(nack_ret > 0, "R5", "refused resends seen", 64'(nack_ret), 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule